// File: doc/BRIEF.md
# I2C Master Byte Buffer and Status Unit

This block sits between a CPU register port and the byte engine of an I2C master. Outbound bytes written by the CPU wait in a two-entry transmit queue until the engine takes them. Inbound bytes delivered by the engine wait in a two-entry receive queue until the CPU reads them. The engine side uses a simple per-byte handshake, and the engine also reports when an address phase was not acknowledged.

The CPU sees four 16-bit registers, selected by a 2-bit address: status at 0, receive data at 1, transmit data at 2, and control at 3. Reads return data in the same cycle. Reading the status register clears the sticky event bits. Reading receive data consumes a byte.

The status word packs the following fields:
- a two-bit transmit fill code
- the transmit and receive request flags
- the address-NACK flag
- a receive overflow flag

Each of the three request/event flags can be enabled onto a single registered interrupt output.

Top module: `i2c_fifo_stat`

## Requirements
- R1: Each queue holds at most 2 bytes. A CPU write to transmit data (address 2) while the transmit queue holds 2 bytes is discarded, even if the engine takes a byte in the same cycle.
- R2: Status bits [1:0] give the transmit fill: 00 when empty, 10 when one byte is held, 11 when two are held.
- R3: Status bit 3 (receive request) is 1 exactly when the receive queue holds at least one byte.
- R4: Status bit 2 (transmit request) is 1 exactly when control bit 0 (direction) is 0 and the transmit queue holds fewer than 2 bytes.
- R5: Status bit 4 (address NACK) is set the cycle after `eng_nack` is high. It is cleared by a status read (address 0). When both happen in one cycle, the flag ends up set.
- R6: `irq` is high in the cycle after any of these holds: NACK with control bit 3 set, receive request with control bit 2 set, or transmit request with control bit 1 set. Otherwise `irq` is low.
- R7: Reading transmit data returns in bits [7:0] the byte most recently taken by the engine (the one on the line), not the queued head. It reads 0 after reset.
- R8: Bits [15:8] of the receive-data and transmit-data reads are 0. Only bits [3:0] of control are stored; the other control bits read 0. The status bits above bit 5 read 0.
- R9: A byte offered by the engine while the receive queue holds 2 bytes is dropped. Such a drop sets status bit 5 (overflow). A status read clears it, and a drop in the same cycle as the read wins.
- R10: A receive-data read returns the oldest received byte and removes it. When the queue is empty it returns 0 and changes nothing.
- R11: `eng_tx_valid` is high when the transmit queue is non-empty, and `eng_tx_data` shows its oldest byte. `eng_tx_take` removes that byte only when `eng_tx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, same cycle |
| eng_tx_valid | output | 1 | Transmit byte available |
| eng_tx_data | output | 8 | Oldest queued transmit byte |
| eng_tx_take | input | 1 | Engine takes the transmit byte |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_nack | input | 1 | Address phase was not acknowledged |
| irq | output | 1 | Registered interrupt |

## Verification
The bench targets the following corner cases:
- A write into a full transmit queue in the same cycle as an engine take. A design that frees the slot early would queue a third byte.
- A status read colliding with a NACK event or a receive overflow. A wrong priority would lose the event.
- Reading transmit data while bytes are queued. A design returning the queue head would show the next byte instead of the one on the line.
- Reads of an empty receive queue, and the one-cycle interrupt latency under enable changes. A combinational or unmasked interrupt would be caught immediately.

// File: rtl/i2cfs_pkg.sv
package i2cfs_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 16;

  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_RXD  = 2'd1,
    A_TXD  = 2'd2,
    A_CTRL = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic ie_nack;
    logic ie_rx;
    logic ie_tx;
    logic dir_rd;
  } ctrl_t;

  // fill code: empty 00, partial 10, full 11
  function automatic logic [1:0] fill_code(input int unsigned cnt, input int unsigned depth);
    if (cnt == 0)          return 2'b00;
    else if (cnt >= depth) return 2'b11;
    else                   return 2'b10;
  endfunction
endpackage

// File: rtl/i2cfs_byte_fifo.sv
module i2cfs_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] wr_idx;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign drop    = push && full;
  assign wr_idx  = wrap_add(rd_ptr, int'(count));
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push_ok) mem[wr_idx] <= din;
      if (pop_ok) rd_ptr <= wrap_add(rd_ptr, 1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R1
  full_pop_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop) |=> (count == CW'(DEPTH - 1)));
endmodule

// File: rtl/i2cfs_sticky_bit.sv
module i2cfs_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set | (q & ~clr);
  end

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
endmodule

// File: rtl/i2cfs_irq_unit.sv
module i2cfs_irq_unit #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] en,
  output logic         irq
);
  logic irq_next;
  assign irq_next = |(flags & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_next;
  end

  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !irq);
endmodule

// File: rtl/i2c_fifo_stat.sv
module i2c_fifo_stat
  import i2cfs_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              eng_tx_valid,
  output logic [BYTE_W-1:0] eng_tx_data,
  input  logic              eng_tx_take,
  input  logic              eng_rx_valid,
  input  logic [BYTE_W-1:0] eng_rx_data,
  input  logic              eng_nack,
  output logic              irq
);
  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] cur_tx;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, tx_drop;
  logic              rx_full, rx_empty, rx_drop;
  logic [BYTE_W-1:0] rx_head;
  logic              nack_q, ovf_q;
  logic              stat_rd, rxd_rd, txd_wr, ctrl_wr, tx_pop;
  logic              tx_req, rx_req;
  logic [REG_W-1:0]  stat_word;
  logic [7:0]        wdata_unused;

  assign wdata_unused = reg_wdata[15:8];
  assign stat_rd = reg_rd && (reg_addr == A_STAT);
  assign rxd_rd  = reg_rd && (reg_addr == A_RXD);
  assign txd_wr  = reg_wr && (reg_addr == A_TXD);
  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign tx_pop  = eng_tx_take && !tx_empty;

  i2cfs_byte_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(txd_wr), .din(reg_wdata[BYTE_W-1:0]),
    .pop(eng_tx_take), .dout(eng_tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty), .drop(tx_drop)
  );

  i2cfs_byte_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(eng_rx_valid), .din(eng_rx_data),
    .pop(rxd_rd), .dout(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty), .drop(rx_drop)
  );

  i2cfs_sticky_bit u_nack (
    .clk(clk), .rst_n(rst_n), .set(eng_nack), .clr(stat_rd), .q(nack_q)
  );

  i2cfs_sticky_bit u_ovf (
    .clk(clk), .rst_n(rst_n), .set(rx_drop), .clr(stat_rd), .q(ovf_q)
  );

  assign eng_tx_valid = !tx_empty;
  assign tx_req = !ctrl_q.dir_rd && !tx_full;
  assign rx_req = !rx_empty;

  i2cfs_irq_unit #(.N(3)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .flags({nack_q, rx_req, tx_req}),
    .en({ctrl_q.ie_nack, ctrl_q.ie_rx, ctrl_q.ie_tx}),
    .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cur_tx <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata[3:0]);
      if (tx_pop)  cur_tx <= eng_tx_data;
    end
  end

  assign stat_word = {10'd0, ovf_q, nack_q, rx_req, tx_req,
                      fill_code(int'(tx_cnt), DEPTH)};

  always_comb begin
    unique case (reg_sel_e'(reg_addr))
      A_STAT:  reg_rdata = stat_word;
      A_RXD:   reg_rdata = rx_empty ? '0 : {8'd0, rx_head};
      A_TXD:   reg_rdata = {8'd0, cur_tx};
      A_CTRL:  reg_rdata = {12'd0, ctrl_q};
      default: reg_rdata = '0;
    endcase
  end

  // R7
  cur_tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_take && eng_tx_valid) |=> (cur_tx == $past(eng_tx_data)));
  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_valid && rx_full) |=> ovf_q);
  // R4
  txreq_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && reg_wdata[0] |=> !stat_word[2]);
endmodule

// File: tb/i2c_fifo_stat_test.sv
module i2c_fifo_stat_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [15:0] reg_wdata, reg_rdata;
  logic        eng_tx_valid;
  logic [7:0]  eng_tx_data;
  logic        eng_tx_take, eng_rx_valid, eng_nack;
  logic [7:0]  eng_rx_data;
  logic        irq;

  always #10 clk = ~clk;

  i2c_fifo_stat uut (.*);

  // bench model
  logic [7:0] tq [2];
  logic [7:0] rq [2];
  int         tcnt, rcnt;
  logic [7:0] cur_m;
  logic       nack_m, ovf_m, irq_m;
  logic [3:0] ctrl_m;
  int         errs = 0, checks = 0;
  bit         done = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] code_m(input int c);
    case (c)
      0:       return 2'b00;
      1:       return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic txreq_m();
    return !ctrl_m[0] && (tcnt < 2);
  endfunction

  function automatic logic [15:0] stat_m();
    return {10'd0, ovf_m, nack_m, rcnt > 0, txreq_m(), code_m(tcnt)};
  endfunction

  function automatic logic [15:0] read_m(input logic [1:0] a);
    case (a)
      2'd0:    return stat_m();
      2'd1:    return (rcnt > 0) ? {8'd0, rq[0]} : 16'd0;
      2'd2:    return {8'd0, cur_m};
      default: return {12'd0, ctrl_m};
    endcase
  endfunction

  task automatic step(input logic wr, input logic rd, input logic [1:0] a,
                      input logic [15:0] wd, input logic take, input logic rxv,
                      input logic [7:0] rxd, input logic nk, input string tag);
    logic tx_full_pre, rx_full_pre, st_rd;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    eng_tx_take = take; eng_rx_valid = rxv; eng_rx_data = rxd; eng_nack = nk;
    #1;
    chk({tag, " R6 irq"}, {15'd0, irq}, {15'd0, irq_m});
    chk({tag, " R11 tx_valid"}, {15'd0, eng_tx_valid}, {15'd0, tcnt > 0});
    if (tcnt > 0) chk({tag, " R11 tx_data"}, {8'd0, eng_tx_data}, {8'd0, tq[0]});
    if (rd) chk({tag, " read R2 R3 R4 R5 R7 R8 R9 R10"}, reg_rdata, read_m(a));
    @(posedge clk);
    irq_m = (nack_m & ctrl_m[3]) | ((rcnt > 0) & ctrl_m[2]) | (txreq_m() & ctrl_m[1]);
    tx_full_pre = (tcnt == 2);
    rx_full_pre = (rcnt == 2);
    st_rd = rd && (a == 2'd0);
    if (take && tcnt > 0) begin
      cur_m = tq[0]; tq[0] = tq[1]; tcnt--;
    end
    if (wr && a == 2'd2 && !tx_full_pre) begin
      tq[tcnt] = wd[7:0]; tcnt++;
    end
    if (rd && a == 2'd1 && rcnt > 0) begin
      rq[0] = rq[1]; rcnt--;
    end
    ovf_m = (rxv && rx_full_pre) | (ovf_m & !st_rd);
    if (rxv && !rx_full_pre) begin
      rq[rcnt] = rxd; rcnt++;
    end
    nack_m = nk | (nack_m & !st_rd);
    if (wr && a == 2'd3) ctrl_m = wd[3:0];
  endtask

  task automatic rd_reg(input logic [1:0] a, input string tag);
    step(0, 1, a, 16'h0, 0, 0, 8'h0, 0, tag);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d, input string tag);
    step(1, 0, a, d, 0, 0, 8'h0, 0, tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    eng_tx_take = 0; eng_rx_valid = 0; eng_rx_data = 0; eng_nack = 0;
    tcnt = 0; rcnt = 0; cur_m = 0; nack_m = 0; ovf_m = 0; irq_m = 0; ctrl_m = 0;
    tq[0] = 0; tq[1] = 0; rq[0] = 0; rq[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // reset state
    rd_reg(2'd0, "reset R2 R4");
    rd_reg(2'd1, "reset R10 R8");
    rd_reg(2'd2, "reset R7");
    rd_reg(2'd3, "reset R8 ctrl");

    // transmit fill and drop
    wr_reg(2'd3, 16'hFFFE, "R8 ctrl write");
    rd_reg(2'd3, "R8 ctrl readback");
    wr_reg(2'd2, 16'h12A5, "R1 tx push");
    rd_reg(2'd0, "R2 one byte");
    wr_reg(2'd2, 16'h003C, "R1 tx push");
    wr_reg(2'd2, 16'h0077, "R1 drop full");
    rd_reg(2'd0, "R2 R4 full");
    step(0, 0, 2'd0, 0, 1, 0, 0, 0, "R11 take");
    rd_reg(2'd2, "R7 on line");
    wr_reg(2'd2, 16'h0066, "R1 refill");
    step(1, 0, 2'd2, 16'h0099, 1, 0, 0, 0, "R1 full push with take");
    rd_reg(2'd2, "R7 on line second");
    step(0, 0, 2'd0, 0, 1, 0, 0, 0, "R11 take last");
    step(0, 1, 2'd2, 0, 1, 0, 0, 0, "R11 take empty R7");
    rd_reg(2'd0, "R2 empty");

    // receive fill and overflow
    step(0, 0, 2'd0, 0, 0, 1, 8'h11, 0, "R3 rx push");
    step(0, 0, 2'd0, 0, 0, 1, 8'h22, 0, "R3 rx push");
    step(0, 0, 2'd0, 0, 0, 1, 8'h33, 0, "R9 rx drop");
    step(0, 1, 2'd0, 0, 0, 1, 8'h44, 0, "R9 read with drop");
    rd_reg(2'd0, "R9 still set");
    rd_reg(2'd0, "R9 cleared");
    rd_reg(2'd1, "R10 first");
    rd_reg(2'd1, "R10 second");
    rd_reg(2'd1, "R10 empty");
    rd_reg(2'd0, "R3 empty");

    // nack priority
    step(0, 0, 2'd0, 0, 0, 0, 0, 1, "R5 nack");
    step(0, 1, 2'd0, 0, 0, 0, 0, 1, "R5 read with nack");
    rd_reg(2'd0, "R5 still set");
    rd_reg(2'd0, "R5 cleared");

    // direction and masking
    wr_reg(2'd3, 16'h0001, "R4 dir read");
    rd_reg(2'd0, "R4 no txreq");
    step(0, 0, 2'd0, 0, 0, 1, 8'h5A, 1, "R6 masked events");
    step(0, 0, 2'd0, 0, 0, 0, 0, 0, "R6 masked idle");
    wr_reg(2'd3, 16'h0008, "R6 enable nack");
    step(0, 0, 2'd0, 0, 0, 0, 0, 0, "R6 nack irq");
    rd_reg(2'd0, "R5 clear");
    step(0, 0, 2'd0, 0, 0, 0, 0, 0, "R6 irq drop");
    step(0, 0, 2'd0, 0, 0, 0, 0, 0, "R6 irq low");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] r;
      logic wr, rd, take, rxv, nk;
      logic [1:0] a;
      logic [15:0] wd;
      r = 4'($urandom_range(0, 15));
      a = 2'($urandom_range(0, 3));
      wr = (r < 5);
      rd = (r >= 4) && (r < 11);
      if (wr && a == 2'd3 && ($urandom_range(0, 3) != 0)) a = 2'd2;
      wd = 16'($urandom());
      take = ($urandom_range(0, 3) == 0);
      rxv = ($urandom_range(0, 3) == 0);
      nk = ($urandom_range(0, 15) == 0);
      step(wr, rd, a, wd, take, rxv, 8'($urandom()), nk, "random");
    end
    summary();
  end
endmodule